// File: doc/BRIEF.md
# Reinforcement-Learning DRAM Command Picker

This block decides, once per controller decision cycle, which kind of DRAM command the memory controller should issue next. It does not use a fixed priority rule. It holds a table of learned long-term values, one per pair of (quantised system state, candidate command). It issues the timing-legal command whose value is highest. The table is refined online with a temporal-difference update driven by the reward the previous choice earned: one unit for each data-moving command and nothing for any other command.

The surrounding controller presents six occupancy counters describing the transaction queue and the reorder buffer, plus a mask of the commands that are timing-legal in this cycle. It raises a strobe when it wants a decision. One cycle later the block answers with the chosen command code, the state index it used, and a flag telling whether the choice was an exploratory random pick. Timing enforcement, addresses and request queueing all stay in the surrounding controller.

Top module: `dram_rl_sched`

## Requirements
- R1: While reset is asserted and afterwards until the first decision, o_valid, o_cmd and o_explore read 0. Reset loads every table entry with the same nonzero value (1.0, which is 256 in the 8-fraction-bit format). The first greedy decision after reset therefore returns the lowest legal command code.
- R2: Each of the six counters is saturated to 3 and kept as 2 bits. The read count goes to bits 1:0 of a 12-bit word. Above it come the write count, the load-miss count, the pending-write count, the waiting-head count, and the relative order in bits 11:10. The state index reported on o_idx is bits 5:0 XOR bits 11:6 of that word.
- R3: The chosen command is always legal. Bit n of i_legal permits command code n. Code 6 (no-operation) is legal whatever i_legal bit 6 holds.
- R4: The command codes are as follows: 0 read for a load miss, 1 read for a store miss, 2 write, 3 activate, 4 precharge for a pending request, 5 preemptive precharge, 6 no-operation. Outside exploration, the block picks the legal code with the largest table value for the current state. Among equal values, the lowest code wins.
- R5: The reward credited to a decision is 1.0 (256) when its command code is 0, 1 or 2, and 0 otherwise.
- R6: At every decision except the first after reset, the entry of the previous decision is updated. The update is old + ((r + q - (q>>>3) - old) >>>2), clamped to 0..65535. Here r is the previous decision's reward and q is the current table value of the pair just chosen, both read before this update. Decisions use the table as it was before the update made in the same cycle.
- R7: A 16-bit shift register seeded with 0xACE1 shifts left once per decision. The bit shifted in is bit15^bit13^bit12^bit10. When its low byte is below 16, the pick is exploratory and o_explore is 1. In that case the search starts at code bits 10:8, with 7 treated as 0, and returns the first legal code found, wrapping 6 to 0.
- R8: o_valid is 1 exactly in the cycle after i_valid was high. Cycles without i_valid neither change the table nor advance the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Request a decision this cycle |
| i_rd_cnt | input | CNT_W | Reads in the transaction queue |
| i_wr_cnt | input | CNT_W | Writes in the transaction queue |
| i_ldmiss_cnt | input | CNT_W | Load misses in the transaction queue |
| i_pendwr_cnt | input | CNT_W | Pending writes |
| i_robwait_cnt | input | CNT_W | Reorder-buffer heads waiting on a referenced row |
| i_roborder | input | CNT_W | Relative reorder-buffer order of the request |
| i_legal | input | 7 | Timing-legal command mask, bit n for code n |
| o_valid | output | 1 | Decision result valid |
| o_cmd | output | 3 | Chosen command code |
| o_idx | output | IDX_W | State index used for the decision |
| o_explore | output | 1 | Choice was an exploratory pick |

## Verification
The assertions assume that i_valid stays low while reset is asserted, so the registered outputs line up with the strobe of the cycle before. They also assume that input values are settled at each rising edge. The counters and the legal mask may take any value, because no-operation is forced legal internally. The stimulus holds i_valid low through reset and changes inputs only just after a rising edge. It draws the counters from a narrow range so that states recur and learned values come to differ.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NUM_ACT  = 7;
  localparam int NUM_ATTR = 6;
  localparam int ATTR_Q_W = 2;
  localparam int LFSR_W   = 16;
  localparam int CMD_W    = 3;

  typedef enum logic [CMD_W-1:0] {
    ACT_RD_LOAD  = 3'd0,
    ACT_RD_STORE = 3'd1,
    ACT_WRITE    = 3'd2,
    ACT_ACTIVATE = 3'd3,
    ACT_PRE_PEND = 3'd4,
    ACT_PRE_SPEC = 3'd5,
    ACT_NOP      = 3'd6
  } cmd_e;
endpackage

// File: rtl/sched_state_quant.sv
module sched_state_quant
  import sched_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int IDX_W = 6
) (
  input  logic [NUM_ATTR*CNT_W-1:0] attrs,
  output logic [IDX_W-1:0]          idx
);
  localparam int CAT_W = NUM_ATTR*ATTR_Q_W;
  localparam logic [CNT_W-1:0] SAT_MAX = CNT_W'((1 << ATTR_Q_W) - 1);

  logic [CAT_W-1:0] cat_w;

  for (genvar g = 0; g < NUM_ATTR; g++) begin : g_sat
    logic [CNT_W-1:0] raw;
    assign raw = attrs[g*CNT_W +: CNT_W];
    assign cat_w[g*ATTR_Q_W +: ATTR_Q_W] =
      (raw > SAT_MAX) ? SAT_MAX[ATTR_Q_W-1:0] : raw[ATTR_Q_W-1:0];
  end

  always_comb begin
    idx = '0;
    for (int b = 0; b < CAT_W; b++) begin
      idx[b % IDX_W] = idx[b % IDX_W] ^ cat_w[b];
    end
  end
endmodule

// File: rtl/sched_lfsr.sv
module sched_lfsr
  import sched_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (adv) begin
      state_d = {state_q[LFSR_W-2:0],
                 state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R8
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q));
endmodule

// File: rtl/sched_select.sv
module sched_select
  import sched_pkg::*;
#(
  parameter int Q_W      = 16,
  parameter int EXPL_THR = 16
) (
  input  logic [NUM_ACT*Q_W-1:0] vals,
  input  logic [NUM_ACT-1:0]     legal,
  input  logic [10:0]            rnd,
  output logic [CMD_W-1:0]       cmd,
  output logic                   explore
);
  logic [CMD_W-1:0] g_sel, r_sel;
  logic [Q_W-1:0]   g_best;
  logic             g_found, r_found;
  int               start, c;

  // greedy: strict compare in ascending order keeps the lowest code on ties
  always_comb begin
    g_sel   = CMD_W'(ACT_NOP);
    g_best  = '0;
    g_found = 1'b0;
    for (int i = 0; i < NUM_ACT; i++) begin
      if (legal[i] && (!g_found || vals[i*Q_W +: Q_W] > g_best)) begin
        g_found = 1'b1;
        g_best  = vals[i*Q_W +: Q_W];
        g_sel   = CMD_W'(i);
      end
    end
  end

  // exploration: rotate from a random start to the first legal code
  always_comb begin
    start   = int'(rnd[10:8]);
    if (start >= NUM_ACT) start = 0;
    r_sel   = CMD_W'(ACT_NOP);
    r_found = 1'b0;
    c       = 0;
    for (int j = 0; j < NUM_ACT; j++) begin
      c = start + j;
      if (c >= NUM_ACT) c = c - NUM_ACT;
      if (!r_found && legal[c]) begin
        r_found = 1'b1;
        r_sel   = CMD_W'(c);
      end
    end
  end

  assign explore = int'(rnd[7:0]) < EXPL_THR;
  assign cmd     = explore ? r_sel : g_sel;

  always_comb begin
    if (!explore) begin
      for (int k = 0; k < NUM_ACT; k++) begin
        // R4
        greedy_max_chk: assert (!(legal[k] &&
          ((vals[k*Q_W +: Q_W] > vals[cmd*Q_W +: Q_W]) ||
           ((vals[k*Q_W +: Q_W] == vals[cmd*Q_W +: Q_W]) && (k < int'(cmd))))));
      end
    end
  end
endmodule

// File: rtl/sched_qtable.sv
module sched_qtable
  import sched_pkg::*;
#(
  parameter int Q_W      = 16,
  parameter int IDX_W    = 6,
  parameter int FRAC     = 8,
  parameter int INIT_Q   = 256,
  parameter int ALPHA_SH = 2,
  parameter int GAMMA_SH = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [NUM_ACT*Q_W-1:0] rd_row,
  input  logic                   upd_en,
  input  logic [IDX_W-1:0]       upd_idx,
  input  logic [CMD_W-1:0]       upd_act,
  input  logic                   upd_reward,
  input  logic [Q_W-1:0]         boot_q
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int EXT_W = Q_W + 3;
  localparam logic [Q_W-1:0] INIT_V = Q_W'(INIT_Q);
  localparam logic signed [EXT_W-1:0] ONE_S = EXT_W'(1 << FRAC);
  localparam logic signed [EXT_W-1:0] MAX_S = {3'b000, {Q_W{1'b1}}};

  logic [Q_W-1:0] mem_q [DEPTH][NUM_ACT];
  logic [Q_W-1:0] old_q, wr_val;
  logic signed [EXT_W-1:0] old_s, boot_s, rew_s, tgt_s, dlt_s, sum_s;

  always_comb begin
    for (int a = 0; a < NUM_ACT; a++) rd_row[a*Q_W +: Q_W] = mem_q[rd_idx][a];
  end

  assign old_q  = mem_q[upd_idx][upd_act];
  assign old_s  = $signed({3'b000, old_q});
  assign boot_s = $signed({3'b000, boot_q});
  assign rew_s  = upd_reward ? ONE_S : '0;
  assign tgt_s  = rew_s + boot_s - (boot_s >>> GAMMA_SH);
  assign dlt_s  = tgt_s - old_s;
  assign sum_s  = old_s + (dlt_s >>> ALPHA_SH);

  always_comb begin
    if (sum_s < 0)          wr_val = '0;
    else if (sum_s > MAX_S) wr_val = '1;
    else                    wr_val = sum_s[Q_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < DEPTH; d++)
        for (int a = 0; a < NUM_ACT; a++) mem_q[d][a] <= INIT_V;
    end else if (upd_en) begin
      mem_q[upd_idx][upd_act] <= wr_val;
    end
  end

  // R6
  upd_act_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (int'(upd_act) < NUM_ACT));
endmodule

// File: rtl/dram_rl_sched.sv
module dram_rl_sched
  import sched_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int IDX_W    = 6,
  parameter int Q_W      = 16,
  parameter int FRAC     = 8,
  parameter int INIT_Q   = 256,
  parameter int ALPHA_SH = 2,
  parameter int GAMMA_SH = 3,
  parameter int EXPL_THR = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               i_valid,
  input  logic [CNT_W-1:0]   i_rd_cnt,
  input  logic [CNT_W-1:0]   i_wr_cnt,
  input  logic [CNT_W-1:0]   i_ldmiss_cnt,
  input  logic [CNT_W-1:0]   i_pendwr_cnt,
  input  logic [CNT_W-1:0]   i_robwait_cnt,
  input  logic [CNT_W-1:0]   i_roborder,
  input  logic [6:0]         i_legal,
  output logic               o_valid,
  output logic [2:0]         o_cmd,
  output logic [IDX_W-1:0]   o_idx,
  output logic               o_explore
);
  localparam int ATTR_BUS_W = NUM_ATTR*CNT_W;
  localparam logic [NUM_ACT-1:0] NOP_BIT = NUM_ACT'(1) << ACT_NOP;

  logic [ATTR_BUS_W-1:0]  attr_bus;
  logic [IDX_W-1:0]       cur_idx;
  logic [LFSR_W-1:0]      rnd;
  logic [NUM_ACT-1:0]     legal_eff;
  logic [NUM_ACT*Q_W-1:0] row;
  logic [CMD_W-1:0]       sel_cmd;
  logic                   sel_expl;
  logic                   prev_rew;

  logic                   prev_vld_q, prev_vld_d;
  logic [IDX_W-1:0]       prev_idx_q, prev_idx_d;
  logic [CMD_W-1:0]       prev_act_q, prev_act_d;
  logic                   vld_q, vld_d, expl_q, expl_d;
  logic [CMD_W-1:0]       cmd_q, cmd_d;
  logic [IDX_W-1:0]       idx_q, idx_d;

  assign attr_bus  = {i_roborder, i_robwait_cnt, i_pendwr_cnt,
                      i_ldmiss_cnt, i_wr_cnt, i_rd_cnt};
  assign legal_eff = i_legal | NOP_BIT;

  sched_state_quant #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_quant (
    .attrs (attr_bus),
    .idx   (cur_idx)
  );

  sched_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (i_valid),
    .state (rnd)
  );

  sched_select #(.Q_W(Q_W), .EXPL_THR(EXPL_THR)) u_select (
    .vals    (row),
    .legal   (legal_eff),
    .rnd     (rnd[10:0]),
    .cmd     (sel_cmd),
    .explore (sel_expl)
  );

  assign prev_rew = (prev_act_q <= CMD_W'(ACT_WRITE));

  sched_qtable #(
    .Q_W(Q_W), .IDX_W(IDX_W), .FRAC(FRAC), .INIT_Q(INIT_Q),
    .ALPHA_SH(ALPHA_SH), .GAMMA_SH(GAMMA_SH)
  ) u_qtable (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (cur_idx),
    .rd_row     (row),
    .upd_en     (i_valid & prev_vld_q),
    .upd_idx    (prev_idx_q),
    .upd_act    (prev_act_q),
    .upd_reward (prev_rew),
    .boot_q     (row[sel_cmd*Q_W +: Q_W])
  );

  always_comb begin
    prev_vld_d = prev_vld_q;
    prev_idx_d = prev_idx_q;
    prev_act_d = prev_act_q;
    vld_d      = i_valid;
    cmd_d      = cmd_q;
    idx_d      = idx_q;
    expl_d     = 1'b0;
    if (i_valid) begin
      prev_vld_d = 1'b1;
      prev_idx_d = cur_idx;
      prev_act_d = sel_cmd;
      cmd_d      = sel_cmd;
      idx_d      = cur_idx;
      expl_d     = sel_expl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld_q <= 1'b0;
      prev_idx_q <= '0;
      prev_act_q <= '0;
      vld_q      <= 1'b0;
      cmd_q      <= '0;
      idx_q      <= '0;
      expl_q     <= 1'b0;
    end else begin
      prev_vld_q <= prev_vld_d;
      prev_idx_q <= prev_idx_d;
      prev_act_q <= prev_act_d;
      vld_q      <= vld_d;
      cmd_q      <= cmd_d;
      idx_q      <= idx_d;
      expl_q     <= expl_d;
    end
  end

  assign o_valid   = vld_q;
  assign o_cmd     = cmd_q;
  assign o_idx     = idx_q;
  assign o_explore = expl_q;

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid == $past(i_valid));

  // R3
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> ((o_cmd == CMD_W'(ACT_NOP)) ||
                 ((($past(i_legal) >> o_cmd) & 7'd1) != 7'd0)));

  // R7
  explore_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !o_valid |-> !o_explore);

  // R3
  cmd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (int'(o_cmd) < NUM_ACT));
endmodule

// File: tb/tb_dram_rl_sched.sv
`timescale 1ns/1ps
module tb_dram_rl_sched;
  localparam int CNT_W = 4;
  localparam int IDX_W = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             i_valid;
  logic [CNT_W-1:0] i_rd_cnt, i_wr_cnt, i_ldmiss_cnt, i_pendwr_cnt, i_robwait_cnt, i_roborder;
  logic [6:0]       i_legal;
  logic             o_valid, o_explore;
  logic [2:0]       o_cmd;
  logic [IDX_W-1:0] o_idx;

  always #2.5 clk = ~clk;

  dram_rl_sched dut (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid),
    .i_rd_cnt(i_rd_cnt), .i_wr_cnt(i_wr_cnt), .i_ldmiss_cnt(i_ldmiss_cnt),
    .i_pendwr_cnt(i_pendwr_cnt), .i_robwait_cnt(i_robwait_cnt),
    .i_roborder(i_roborder), .i_legal(i_legal),
    .o_valid(o_valid), .o_cmd(o_cmd), .o_idx(o_idx), .o_explore(o_explore)
  );

  typedef struct {
    bit    vld;
    int    cmd;
    int    idx;
    bit    expl;
    int    mask;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   qm[64][7];
  int   lf;
  bit   have_prev;
  int   p_idx, p_act;
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int sat3(int x);
    return (x > 3) ? 3 : x;
  endfunction

  task automatic drive(bit v, int rd, int wr, int lm, int pw, int rw, int ro, int mask, string tag);
    exp_t e;
    int   s, cat, leg, gsel, best, k, rsel, a, nxt, old, tgt, nv, rw_val;
    bit   rfound;
    e.vld = v; e.tag = tag; e.mask = mask; e.cmd = 0; e.idx = 0; e.expl = 0;
    i_valid = v;
    i_rd_cnt = CNT_W'(rd); i_wr_cnt = CNT_W'(wr); i_ldmiss_cnt = CNT_W'(lm);
    i_pendwr_cnt = CNT_W'(pw); i_robwait_cnt = CNT_W'(rw); i_roborder = CNT_W'(ro);
    i_legal = 7'(mask);
    if (v) begin
      cat = sat3(rd) | (sat3(wr) << 2) | (sat3(lm) << 4) | (sat3(pw) << 6)
          | (sat3(rw) << 8) | (sat3(ro) << 10);
      s = (cat & 63) ^ (cat >> 6);
      leg = mask | 64;
      best = -1; gsel = 6;
      for (int i = 0; i < 7; i++)
        if (((leg >> i) & 1) && qm[s][i] > best) begin best = qm[s][i]; gsel = i; end
      k = (lf >> 8) & 7;
      if (k >= 7) k = 0;
      rsel = 6; rfound = 0;
      for (int j = 0; j < 7; j++)
        if (!rfound && ((leg >> ((k + j) % 7)) & 1)) begin rfound = 1; rsel = (k + j) % 7; end
      e.expl = ((lf & 255) < 16);
      a = e.expl ? rsel : gsel;
      e.cmd = a; e.idx = s;
      if (have_prev) begin
        rw_val = (p_act <= 2) ? 256 : 0;
        nxt = qm[s][a];
        old = qm[p_idx][p_act];
        tgt = rw_val + nxt - (nxt >>> 3);
        nv  = old + ((tgt - old) >>> 2);
        if (nv < 0) nv = 0;
        if (nv > 65535) nv = 65535;
        qm[p_idx][p_act] = nv;
      end
      have_prev = 1; p_idx = s; p_act = a;
      lf = ((lf << 1) & 16'hFFFF) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1);
    end
    @(posedge clk);
    sb.push_back(e);
    #1;
    i_valid = 1'b0;
  endtask

  // monitor: one scoreboard item per cycle after the driver starts
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(o_valid == e.vld, "R8 valid", int'(o_valid), int'(e.vld));
      if (e.vld && o_valid) begin
        chk(int'(o_idx) == e.idx, {"R2 idx ", e.tag}, int'(o_idx), e.idx);
        chk(o_explore == e.expl, {"R7 explore ", e.tag}, int'(o_explore), int'(e.expl));
        chk(int'(o_cmd) == e.cmd,
            e.expl ? {"R7 cmd ", e.tag} : {"R4/R5/R6 cmd ", e.tag}, int'(o_cmd), e.cmd);
        chk((o_cmd == 3'd6) || (((e.mask >> o_cmd) & 1) == 1), {"R3 legal ", e.tag},
            int'(o_cmd), e.mask);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    for (int d = 0; d < 64; d++) for (int a = 0; a < 7; a++) qm[d][a] = 256;
    lf = 16'hACE1; have_prev = 0; p_idx = 0; p_act = 0;
    rst_n = 1'b0; i_valid = 1'b0; i_legal = '0;
    i_rd_cnt = '0; i_wr_cnt = '0; i_ldmiss_cnt = '0;
    i_pendwr_cnt = '0; i_robwait_cnt = '0; i_roborder = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(o_valid == 1'b0, "R1 reset valid", int'(o_valid), 0);
    chk(o_cmd == 3'd0, "R1 reset cmd", int'(o_cmd), 0);
    chk(o_explore == 1'b0, "R1 reset explore", int'(o_explore), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: first decision, all entries equal, lowest legal code expected
    drive(1, 1, 0, 0, 0, 0, 0, 7'h7F, "R1 tie");
    drive(1, 0, 0, 0, 0, 0, 0, 7'h0C, "R1 tie-low");
    // R3: nothing legal but no-operation
    drive(1, 15, 15, 15, 15, 15, 15, 7'h00, "R3 nop-only");
    // R8: idle cycles
    drive(0, 0, 0, 0, 0, 0, 0, 7'h7F, "R8 idle");
    drive(0, 0, 0, 0, 0, 0, 0, 7'h7F, "R8 idle");
    // R2: saturation and fold
    drive(1, 3, 4, 2, 1, 0, 9, 7'h04, "R2 sat");
    drive(1, 9, 2, 3, 3, 1, 2, 7'h7F, "R2 fold");
    // R5/R6: same state, write versus activate learning
    for (int n = 0; n < 40; n++) drive(1, 2, 2, 0, 0, 0, 0, 7'h0C, "R5 learn");
    for (int n = 0; n < 30; n++) drive(1, 1, 3, 1, 0, 2, 0, 7'h38, "R6 no-reward");
    // mixed random traffic over a narrow state range
    for (int n = 0; n < 4000; n++) begin
      bit vv;
      vv = (($urandom % 4) != 0);
      drive(vv, $urandom % 6, $urandom % 6, $urandom % 5, $urandom % 5,
            $urandom % 4, $urandom % 4, $urandom % 128, "rand");
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, "drain");
    drive(0, 0, 0, 0, 0, 0, 0, 0, "drain");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule